// File: doc/BRIEF.md
# Renaming Issue Pool for One Functional-Unit Class

This block accepts operations in program order and lets them leave for a functional unit out of order. It holds a small pool of reservation stations and an architectural register file. Each register has a status field that holds the tag of the station that will produce its next value. When an operation is accepted, each of its two source registers is resolved in one of two ways. If no producer is pending, the register value is copied into the station. Otherwise the producer's tag is stored, and the station waits for that tag. The destination register's status is then overwritten with the new station's tag. This renaming removes write-after-read and write-after-write conflicts without any hazard check on the register file.

A functional unit outside the block takes ready operations from the dispatch port. It later returns each result on a single broadcast bus as a tag and data pair. Every waiting station compares its pending tags with the broadcast tag and copies the value on a match. The register file is written only when the register's status still names the broadcasting tag. The station that produced the result becomes free again.

Tag value 0 means "no pending producer". Station k, counted from 0, carries tag k+1.

Top module: `rs_pool`

## Requirements
- R1: After reset no station is occupied: issueReady is 1, issueTag is 1, dispValid is 0, no register has a pending producer, and register r holds the value r.
- R2: An accepted issue (issueValid and issueReady) takes the lowest-numbered free station, whose tag is shown on issueTag. When every station is occupied, issueReady is 0 and an issue request changes nothing.
- R3: A source register with no pending producer supplies its register-file value to the station at issue.
- R4: A source register with a pending producer makes the station record that tag. The station is not offered for dispatch until that tag is broadcast, and it then carries the broadcast data.
- R5: If the tag a new operation needs is broadcast in the same cycle that the operation issues, the station takes the broadcast data and is not left waiting on the tag.
- R6: dispValid is 1 whenever some occupied, not yet dispatched station has no pending tag. dispTag names the lowest-numbered such station. A station is dispatched once, in the cycle where dispValid and dispReady are both 1. While dispReady is 0, the offer stays valid.
- R7: A station is freed by the broadcast of its own tag, and it can be issued to from the next cycle on.
- R8: A broadcast writes a register only when that register's status holds the broadcast tag. When several writers to one register are in flight, only the last-issued one updates it.
- R9: The operation code and the immediate given at issue appear unchanged at dispatch.
- R10: When a destination equals one of its own sources, the source is resolved against the register status as it was before this issue renamed the destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| issueValid | input | 1 | Issue request |
| issueOp | input | OP_W | Operation code |
| issueDst | input | REG_W | Destination register |
| issueSrcJ | input | REG_W | First source register |
| issueSrcK | input | REG_W | Second source register |
| issueImm | input | IMM_W | Immediate or address field |
| issueReady | output | 1 | A station is free |
| issueTag | output | TAG_W | Tag an accepted issue receives |
| dispValid | output | 1 | A station is ready to dispatch |
| dispReady | input | 1 | Functional unit accepts the offer |
| dispTag | output | TAG_W | Tag of the offered station |
| dispOp | output | OP_W | Offered operation code |
| dispVj | output | DATA_W | First operand value |
| dispVk | output | DATA_W | Second operand value |
| dispImm | output | IMM_W | Offered immediate |
| cdbValid | input | 1 | Result broadcast valid |
| cdbTag | input | TAG_W | Tag of the broadcast result |
| cdbData | input | DATA_W | Broadcast result value |

## Verification
Several activities can fall in one cycle, and the bench schedules them together on purpose:
- An issue coincides with a broadcast of a tag the new operation needs. The bench checks that the value, not the stale tag, reaches dispatch.
- An issue that renames a register coincides with an older writer's broadcast to that register. The bench checks that only the last-issued writer's value is later read from the register file.
- A dispatch coincides with a broadcast that frees another station.

A behavioural model in the bench predicts every output, and the bench compares it with the design on each cycle.

// File: rtl/rs_pool_pkg.sv
package rs_pool_pkg;
  // Width of station indices carried in the strobe bundle (pools up to 15 stations).
  localparam int SLOT_W = 4;

  typedef struct packed {
    logic              doIssue;
    logic [SLOT_W-1:0] issueSlot;
    logic              doDisp;
    logic [SLOT_W-1:0] dispSlot;
  } rsStrobe_t;
endpackage

// File: rtl/rs_pool_ctrl.sv
module rs_pool_ctrl
  import rs_pool_pkg::*;
#(
  parameter int NUM_RS = 3
) (
  input  logic [NUM_RS-1:0] busyVec,
  input  logic [NUM_RS-1:0] readyVec,
  input  logic              issueValid,
  input  logic              dispReady,
  output logic              issueReady,
  output logic              dispValid,
  output rsStrobe_t         strobe
);

  // Lowest index wins: scan from the top so the last hit is the smallest.
  always_comb begin
    strobe     = '0;
    issueReady = 1'b0;
    dispValid  = 1'b0;
    for (int s = NUM_RS - 1; s >= 0; s--) begin
      if (!busyVec[s]) begin
        issueReady       = 1'b1;
        strobe.issueSlot = SLOT_W'(s);
      end
      if (readyVec[s]) begin
        dispValid       = 1'b1;
        strobe.dispSlot = SLOT_W'(s);
      end
    end
    strobe.doIssue = issueValid && issueReady;
    strobe.doDisp  = dispValid && dispReady;
  end

endmodule

// File: rtl/rs_pool_dp.sv
module rs_pool_dp
  import rs_pool_pkg::*;
#(
  parameter int NUM_RS   = 3,
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int OP_W     = 3,
  parameter int IMM_W    = 8,
  parameter int TAG_W    = 2,
  parameter int REG_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  rsStrobe_t         strobe,
  input  logic [TAG_W-1:0]  issueTag,
  input  logic [OP_W-1:0]   issueOp,
  input  logic [REG_W-1:0]  issueDst,
  input  logic [REG_W-1:0]  issueSrcJ,
  input  logic [REG_W-1:0]  issueSrcK,
  input  logic [IMM_W-1:0]  issueImm,
  input  logic              cdbValid,
  input  logic [TAG_W-1:0]  cdbTag,
  input  logic [DATA_W-1:0] cdbData,
  output logic [NUM_RS-1:0] busyVec,
  output logic [NUM_RS-1:0] readyVec,
  output logic [OP_W-1:0]   dispOp,
  output logic [DATA_W-1:0] dispVj,
  output logic [DATA_W-1:0] dispVk,
  output logic [IMM_W-1:0]  dispImm
);

  logic [NUM_RS-1:0] sentVec;
  logic [OP_W-1:0]   stOp  [NUM_RS];
  logic [DATA_W-1:0] stVj  [NUM_RS];
  logic [DATA_W-1:0] stVk  [NUM_RS];
  logic [TAG_W-1:0]  stQj  [NUM_RS];
  logic [TAG_W-1:0]  stQk  [NUM_RS];
  logic [IMM_W-1:0]  stImm [NUM_RS];
  logic [DATA_W-1:0] regVal [NUM_REGS];
  logic [TAG_W-1:0]  regTag [NUM_REGS];

  logic              cdbHit;
  logic [TAG_W-1:0]  srcTagJ, srcTagK, newQj, newQk;
  logic [DATA_W-1:0] newVj, newVk;

  assign cdbHit = cdbValid && (cdbTag != '0);

  // Source resolution uses the status before this issue renames its destination.
  always_comb begin
    srcTagJ = regTag[issueSrcJ];
    srcTagK = regTag[issueSrcK];
    if (srcTagJ == '0) begin
      newVj = regVal[issueSrcJ]; newQj = '0;
    end else if (cdbHit && srcTagJ == cdbTag) begin
      newVj = cdbData;           newQj = '0;
    end else begin
      newVj = '0;                newQj = srcTagJ;
    end
    if (srcTagK == '0) begin
      newVk = regVal[issueSrcK]; newQk = '0;
    end else if (cdbHit && srcTagK == cdbTag) begin
      newVk = cdbData;           newQk = '0;
    end else begin
      newVk = '0;                newQk = srcTagK;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyVec <= '0;
      sentVec <= '0;
      for (int s = 0; s < NUM_RS; s++) begin
        stOp[s] <= '0; stVj[s] <= '0; stVk[s] <= '0;
        stQj[s] <= '0; stQk[s] <= '0; stImm[s] <= '0;
      end
    end else begin
      for (int s = 0; s < NUM_RS; s++) begin
        if (busyVec[s] && cdbHit) begin
          if (stQj[s] == cdbTag) begin stVj[s] <= cdbData; stQj[s] <= '0; end
          if (stQk[s] == cdbTag) begin stVk[s] <= cdbData; stQk[s] <= '0; end
          if (TAG_W'(s + 1) == cdbTag) begin busyVec[s] <= 1'b0; sentVec[s] <= 1'b0; end
        end
        if (strobe.doDisp && strobe.dispSlot == SLOT_W'(s))
          sentVec[s] <= 1'b1;
        if (strobe.doIssue && strobe.issueSlot == SLOT_W'(s)) begin
          busyVec[s] <= 1'b1;
          sentVec[s] <= 1'b0;
          stOp[s]    <= issueOp;
          stImm[s]   <= issueImm;
          stVj[s]    <= newVj;
          stQj[s]    <= newQj;
          stVk[s]    <= newVk;
          stQk[s]    <= newQk;
        end
      end
    end
  end

  // Register file and status table; a rename in the same cycle overrides the clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        regVal[r] <= DATA_W'(r);
        regTag[r] <= '0;
      end
    end else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (cdbHit && regTag[r] == cdbTag) begin
          regVal[r] <= cdbData;
          regTag[r] <= '0;
        end
        if (strobe.doIssue && issueDst == REG_W'(r))
          regTag[r] <= issueTag;
      end
    end
  end

  for (genvar g = 0; g < NUM_RS; g++) begin : gReady
    assign readyVec[g] = busyVec[g] && !sentVec[g] && (stQj[g] == '0) && (stQk[g] == '0);
  end

  always_comb begin
    dispOp  = '0;
    dispVj  = '0;
    dispVk  = '0;
    dispImm = '0;
    for (int s = 0; s < NUM_RS; s++) begin
      if (strobe.dispSlot == SLOT_W'(s)) begin
        dispOp  = stOp[s];
        dispVj  = stVj[s];
        dispVk  = stVk[s];
        dispImm = stImm[s];
      end
    end
  end

endmodule

// File: rtl/rs_pool.sv
module rs_pool
  import rs_pool_pkg::*;
#(
  parameter int NUM_RS   = 3,
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int OP_W     = 3,
  parameter int IMM_W    = 8,
  localparam int TAG_W   = $clog2(NUM_RS + 1),
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [OP_W-1:0]   issueOp,
  input  logic [REG_W-1:0]  issueDst,
  input  logic [REG_W-1:0]  issueSrcJ,
  input  logic [REG_W-1:0]  issueSrcK,
  input  logic [IMM_W-1:0]  issueImm,
  output logic              issueReady,
  output logic [TAG_W-1:0]  issueTag,
  output logic              dispValid,
  input  logic              dispReady,
  output logic [TAG_W-1:0]  dispTag,
  output logic [OP_W-1:0]   dispOp,
  output logic [DATA_W-1:0] dispVj,
  output logic [DATA_W-1:0] dispVk,
  output logic [IMM_W-1:0]  dispImm,
  input  logic              cdbValid,
  input  logic [TAG_W-1:0]  cdbTag,
  input  logic [DATA_W-1:0] cdbData
);

  rsStrobe_t         strobe;
  logic [NUM_RS-1:0] busyVec;
  logic [NUM_RS-1:0] readyVec;

  assign issueTag = TAG_W'(strobe.issueSlot) + TAG_W'(1);
  assign dispTag  = TAG_W'(strobe.dispSlot) + TAG_W'(1);

  rs_pool_ctrl #(.NUM_RS(NUM_RS)) ctrl (
    .busyVec(busyVec), .readyVec(readyVec),
    .issueValid(issueValid), .dispReady(dispReady),
    .issueReady(issueReady), .dispValid(dispValid), .strobe(strobe)
  );

  rs_pool_dp #(
    .NUM_RS(NUM_RS), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W),
    .OP_W(OP_W), .IMM_W(IMM_W), .TAG_W(TAG_W), .REG_W(REG_W)
  ) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .issueTag(issueTag),
    .issueOp(issueOp), .issueDst(issueDst), .issueSrcJ(issueSrcJ),
    .issueSrcK(issueSrcK), .issueImm(issueImm),
    .cdbValid(cdbValid), .cdbTag(cdbTag), .cdbData(cdbData),
    .busyVec(busyVec), .readyVec(readyVec),
    .dispOp(dispOp), .dispVj(dispVj), .dispVk(dispVk), .dispImm(dispImm)
  );

endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
  parameter int NUM_RS = 3,
  parameter int TAG_W  = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             issueReady,
  input logic [TAG_W-1:0] issueTag,
  input logic             dispValid,
  input logic             dispReady,
  input logic [TAG_W-1:0] dispTag,
  input logic             cdbValid,
  input logic [TAG_W-1:0] cdbTag
);

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rstN |=> (issueReady && !dispValid)); // R1

  AST_ISSUE_TAG_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    issueReady |-> (issueTag != '0 && issueTag <= TAG_W'(NUM_RS))); // R2

  AST_DISP_TAG_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    dispValid |-> (dispTag != '0 && dispTag <= TAG_W'(NUM_RS))); // R6

  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && !dispReady && !(cdbValid && cdbTag == dispTag)) |=> dispValid); // R6

  AST_DISPATCH_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && dispReady) |=> !(dispValid && dispTag == $past(dispTag))); // R6

  AST_FREE_AFTER_BCAST: assert property (@(posedge clk) disable iff (!rstN)
    (!issueReady && cdbValid && cdbTag != '0) |=> issueReady); // R7

endmodule

bind rs_pool rs_pool_chk #(.NUM_RS(NUM_RS), .TAG_W(TAG_W)) chk (
  .clk(clk), .rstN(rstN), .issueReady(issueReady), .issueTag(issueTag),
  .dispValid(dispValid), .dispReady(dispReady), .dispTag(dispTag),
  .cdbValid(cdbValid), .cdbTag(cdbTag)
);

// File: tb/rs_pool_test.sv
module rs_pool_test;
  localparam int CLK_PERIOD = 10;
  localparam int NRS  = 3;
  localparam int NREG = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [2:0]  issueOp = '0, issueDst = '0, issueSrcJ = '0, issueSrcK = '0;
  logic [7:0]  issueImm = '0;
  logic        issueReady, dispValid;
  logic [1:0]  issueTag, dispTag;
  logic        dispReady = 1'b0;
  logic [2:0]  dispOp;
  logic [15:0] dispVj, dispVk;
  logic [7:0]  dispImm;
  logic        cdbValid = 1'b0;
  logic [1:0]  cdbTag = '0;
  logic [15:0] cdbData = '0;

  int checks = 0, fails = 0;
  bit finished = 0;

  // Behavioural reference state
  int mBusy[NRS], mSent[NRS], mOp[NRS], mVj[NRS], mVk[NRS], mQj[NRS], mQk[NRS], mImm[NRS];
  int mRegVal[NREG], mRegTag[NREG];

  rs_pool uut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueOp(issueOp),
    .issueDst(issueDst), .issueSrcJ(issueSrcJ), .issueSrcK(issueSrcK),
    .issueImm(issueImm), .issueReady(issueReady), .issueTag(issueTag),
    .dispValid(dispValid), .dispReady(dispReady), .dispTag(dispTag),
    .dispOp(dispOp), .dispVj(dispVj), .dispVk(dispVk), .dispImm(dispImm),
    .cdbValid(cdbValid), .cdbTag(cdbTag), .cdbData(cdbData)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int iv, input int op, input int dst, input int sj, input int sk,
                      input int imm, input int dr, input int cv, input int ct, input int cd);
    int fs, ds, t, nVj, nQj, nVk, nQk;
    bit hit;
    @(negedge clk);
    fs = -1; ds = -1;
    for (int s = NRS - 1; s >= 0; s--) begin
      if (mBusy[s] == 0) fs = s;
      if (mBusy[s] != 0 && mSent[s] == 0 && mQj[s] == 0 && mQk[s] == 0) ds = s;
    end
    chk("R2", "issueReady", int'(issueReady), int'(fs >= 0));
    if (fs >= 0) chk("R2", "issueTag", int'(issueTag), fs + 1);
    chk("R6", "dispValid", int'(dispValid), int'(ds >= 0));
    if (ds >= 0) begin
      chk("R6", "dispTag", int'(dispTag), ds + 1);
      chk("R9", "dispOp", int'(dispOp), mOp[ds]);
      chk("R9", "dispImm", int'(dispImm), mImm[ds]);
      chk("R4", "dispVj", int'(dispVj), mVj[ds]);
      chk("R4", "dispVk", int'(dispVk), mVk[ds]);
    end
    issueValid = iv[0]; issueOp = op[2:0]; issueDst = dst[2:0];
    issueSrcJ = sj[2:0]; issueSrcK = sk[2:0]; issueImm = imm[7:0];
    dispReady = dr[0]; cdbValid = cv[0]; cdbTag = ct[1:0]; cdbData = cd[15:0];
    // next model state
    hit = (cv != 0) && (ct != 0);
    t = mRegTag[sj];
    if (t == 0) begin nVj = mRegVal[sj]; nQj = 0; end
    else if (hit && t == ct) begin nVj = cd; nQj = 0; end
    else begin nVj = 0; nQj = t; end
    t = mRegTag[sk];
    if (t == 0) begin nVk = mRegVal[sk]; nQk = 0; end
    else if (hit && t == ct) begin nVk = cd; nQk = 0; end
    else begin nVk = 0; nQk = t; end
    for (int s = 0; s < NRS; s++) begin
      if (mBusy[s] != 0 && hit) begin
        if (mQj[s] == ct) begin mVj[s] = cd; mQj[s] = 0; end
        if (mQk[s] == ct) begin mVk[s] = cd; mQk[s] = 0; end
        if (s + 1 == ct) begin mBusy[s] = 0; mSent[s] = 0; end
      end
    end
    if (dr != 0 && ds >= 0) mSent[ds] = 1;
    for (int r = 0; r < NREG; r++)
      if (hit && mRegTag[r] == ct) begin mRegVal[r] = cd; mRegTag[r] = 0; end
    if (iv != 0 && fs >= 0) begin
      mBusy[fs] = 1; mSent[fs] = 0; mOp[fs] = op; mImm[fs] = imm;
      mVj[fs] = nVj; mQj[fs] = nQj; mVk[fs] = nVk; mQk[fs] = nQk;
      mRegTag[dst] = fs + 1;
    end
  endtask

  task automatic idle(input int dr, input int cv, input int ct, input int cd);
    step(0, 0, 0, 0, 0, 0, dr, cv, ct, cd);
  endtask

  initial begin
    for (int s = 0; s < NRS; s++) begin
      mBusy[s] = 0; mSent[s] = 0; mOp[s] = 0; mVj[s] = 0; mVk[s] = 0;
      mQj[s] = 0; mQk[s] = 0; mImm[s] = 0;
    end
    for (int r = 0; r < NREG; r++) begin mRegVal[r] = r; mRegTag[r] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    idle(0, 0, 0, 0);
    chk("R1", "issueReady after reset", int'(issueReady), 1);
    chk("R1", "dispValid after reset", int'(dispValid), 0);
    step(1, 1, 2, 1, 3, 5, 0, 0, 0, 0);
    step(1, 2, 4, 2, 2, 7, 0, 0, 0, 0);
    step(1, 3, 2, 5, 4, 9, 0, 0, 0, 0);       // second writer of r2
    step(1, 6, 6, 6, 6, 6, 1, 0, 0, 0);       // request while full
    chk("R2", "full pool", int'(issueReady), 0);
    chk("R3", "reset reg value j", int'(dispVj), 1);
    chk("R3", "reset reg value k", int'(dispVk), 3);
    idle(0, 0, 0, 0);
    chk("R2", "ignored issue keeps pool full", int'(issueReady), 0);
    chk("R4", "waiting stations not offered", int'(dispValid), 0);
    idle(0, 1, 1, 'h0AAA);
    step(1, 4, 6, 2, 0, 1, 1, 0, 0, 0);
    chk("R7", "station freed", int'(issueReady), 1);
    chk("R7", "freed tag", int'(issueTag), 1);
    chk("R4", "captured value", int'(dispVj), 'h0AAA);
    idle(0, 1, 2, 'h1234);
    step(1, 5, 7, 4, 6, 3, 1, 0, 0, 0);
    idle(0, 1, 3, 'h0777);
    step(1, 6, 1, 2, 7, 'h44, 1, 0, 0, 0);
    chk("R4", "tag3 capture", int'(dispVj), 'h0777);
    idle(0, 1, 1, 'h0101);
    idle(1, 0, 0, 0);
    chk("R8", "regfile written by matching tag", int'(dispVj), 'h1234);
    step(1, 7, 7, 7, 6, 'h11, 0, 1, 2, 'h0BBB); // issue meets broadcast, dst==src
    step(1, 2, 0, 7, 7, 0, 1, 0, 0, 0);
    chk("R5", "same-cycle capture tag", int'(dispTag), 1);
    chk("R5", "same-cycle capture value", int'(dispVj), 'h0BBB);
    idle(1, 1, 1, 'h0F0F);
    chk("R8", "last writer value", int'(dispVj), 'h0777);
    idle(0, 1, 3, 'h0333);
    chk("R6", "offer while not accepted", int'(dispTag), 2);
    idle(1, 0, 0, 0);
    chk("R6", "offer held", int'(dispValid), 1);
    chk("R10", "source before own rename", int'(dispVj), 'h0F0F);
    idle(0, 1, 2, 'h2222);
    step(1, 0, 5, 0, 1, 'hFF, 0, 0, 0, 0);
    idle(1, 0, 0, 0);
    chk("R8", "regfile r0", int'(dispVj), 'h2222);
    chk("R8", "regfile r1", int'(dispVk), 'h0333);
    chk("R9", "immediate", int'(dispImm), 'hFF);
    idle(0, 0, 0, 0);
    idle(0, 0, 0, 0);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule